// File: doc/BRIEF.md
# One-Shot Acceleration Conversion Sequencer

This block runs single acceleration conversions on request while the sensor is set for its on-demand mode. Each accepted trigger switches the analog front end on for a fixed conversion window. The length of the window depends on the selected low-power sub-mode. When the window closes, the front end switches off at once and a data-ready indication is raised. Between conversions the front end stays powered down.

Two trigger sources are available, and a select bit chooses between them. The first is a rising edge on an external trigger pin. The pin is resynchronised to the block clock before its edge is detected. The second is a software write that sets a start bit. That bit stays set while the conversion runs and clears itself when the conversion ends. A rate field of zero keeps the block permanently powered down. Any mode code other than on-demand also keeps it powered down.

The front end is modelled as a cycle timer. It counts the conversion time from a parameterised reference clock, given in kHz (`CLK_KHZ`).

Top module: `od_oneshot_ctrl`

## Requirements
- R1: A conversion can start only when `mode_sel` equals 2'b10. With 2'b00, 2'b01 or 2'b11, `fe_power` stays 0 whatever the triggers do.
- R2: When `rate_sel` is 4'b0000, every trigger from either source is ignored and `fe_power` stays 0.
- R3: With `trig_src` = 0, the pin is sampled at a clock edge t0 where it is high after being low at the edge before. `fe_power` then rises after edge t0+2, the cost of the two synchroniser flops and the edge register. The pin must stay high for at least two clock cycles.
- R4: With `trig_src` = 1, a `sw_start_wr` pulse sampled at edge t makes `fe_power` and `sw_start_bit` 1 after edge t. `sw_start_bit` returns to 0 in the same cycle that `fe_power` falls.
- R5: The source not chosen by `trig_src` has no effect. With `trig_src` = 1 a pin edge is ignored, and with `trig_src` = 0 a write is ignored and `sw_start_bit` stays 0.
- R6: `fe_power` stays high for exactly CLK_KHZ*T/1000 cycles. T is 1200, 1700, 2300 or 3550 µs for `lp_sel` 00, 01, 10 and 11 respectively.
- R7: In the first cycle with `fe_power` low after a conversion, `drdy_stb` is 1, and only for that cycle. `drdy_flag` becomes 1 at the same time and stays 1 until a `drdy_clr` pulse clears it on the next edge. If a completion and a clear fall on the same edge, the completion wins.
- R8: Triggers of either source that arrive while `fe_power` is 1 are ignored. They do not lengthen the conversion and do not cause a second one afterwards.
- R9: `res14` reports the result width of the last started conversion: 0 (12-bit) for `lp_sel` 00, and 1 (14-bit) otherwise. It is captured at start and held until the next start.
- R10: The sub-mode is captured at start. Changing `lp_sel` during a conversion changes neither its length nor `res14`.
- R11: After reset, `fe_power`, `sw_start_bit`, `drdy_stb`, `drdy_flag` and `res14` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode code; 2'b10 is on-demand |
| lp_sel | input | 2 | Low-power sub-mode, which sets the conversion time and result width |
| rate_sel | input | 4 | Rate field; zero locks out all triggers |
| trig_src | input | 1 | Trigger source: 0 selects the pin, 1 selects the software write |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| sw_start_wr | input | 1 | One-cycle write of 1 to the start bit |
| drdy_clr | input | 1 | One-cycle clear of the data-ready flag |
| fe_power | output | 1 | Front end powered and converting |
| sw_start_bit | output | 1 | Readback of the self-clearing start bit |
| drdy_stb | output | 1 | One-cycle data-ready strobe |
| drdy_flag | output | 1 | Sticky data-ready status |
| res14 | output | 1 | Width of the last result: 1 = 14-bit, 0 = 12-bit |

## Verification
The hardest situation to reach from the ports is a second trigger landing in the middle of a running conversion. The same applies to a sub-mode change in that window. The conversion window is hundreds of cycles long and opens only after the synchroniser latency.

The stimulus counts cycles from the rise of `fe_power`. On the tenth cycle of a randomly chosen subset of conversions, it fires a software write and a pin edge and inverts `lp_sel`, all at once. It then checks three things: the measured window still equals the length for the captured sub-mode, `res14` is unchanged, and no further conversion follows.

// File: rtl/od_pkg.sv
package od_pkg;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned SUB_W  = 2;
  localparam int unsigned RATE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_LP_CONT = 2'b00,
    MODE_HP_CONT = 2'b01,
    MODE_ONDEMAND = 2'b10,
    MODE_ILLEGAL = 2'b11
  } od_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } od_state_e;

  // Typical conversion time in microseconds per sub-mode
  function automatic int unsigned conv_us(input logic [SUB_W-1:0] sub);
    case (sub)
      2'b00:   conv_us = 1200;
      2'b01:   conv_us = 1700;
      2'b10:   conv_us = 2300;
      default: conv_us = 3550;
    endcase
  endfunction

  function automatic int unsigned conv_cycles(input int unsigned khz,
                                              input logic [SUB_W-1:0] sub);
    int unsigned c;
    c = (khz * conv_us(sub)) / 1000;
    conv_cycles = (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/od_trig_sync.sv
module od_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_rise
);

  // sh_q[0..STAGES-1] synchroniser chain, sh_q[STAGES] edge history
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d[0] = pin_async;
    for (int i = 1; i <= STAGES; i++) begin
      sh_d[i] = sh_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= sh_d[g];
      end
    end
  endgenerate

  assign pin_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);

endmodule

// File: rtl/od_conv_timer.sv
module od_conv_timer
  import od_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUB_W-1:0] sub,
  output logic             active,
  output logic             done
);

  localparam int unsigned LEN0 = conv_cycles(CLK_KHZ, 2'b00);
  localparam int unsigned LEN1 = conv_cycles(CLK_KHZ, 2'b01);
  localparam int unsigned LEN2 = conv_cycles(CLK_KHZ, 2'b10);
  localparam int unsigned LEN3 = conv_cycles(CLK_KHZ, 2'b11);
  localparam int unsigned CW   = $clog2(LEN3 + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic [CW-1:0] len_m1;

  always_comb begin
    case (sub)
      2'b00:   len_m1 = CW'(LEN0 - 1);
      2'b01:   len_m1 = CW'(LEN1 - 1);
      2'b10:   len_m1 = CW'(LEN2 - 1);
      default: len_m1 = CW'(LEN3 - 1);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = len_m1;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign done   = act_q && (cnt_q == '0);

  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/od_seq.sv
module od_seq
  import od_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig_src,
  input  logic             pin_rise,
  input  logic             sw_wr,
  input  logic             drdy_clr,
  input  logic [SUB_W-1:0] sub,
  input  logic             tmr_active,
  input  logic             tmr_done,
  output logic             load,
  output logic             conv_on,
  output logic             sw_bit,
  output logic             drdy_stb,
  output logic             drdy_flag,
  output logic             res14
);

  od_state_e state_q, state_d;
  logic      sw_q, sw_d;
  logic      stb_q, stb_d;
  logic      flag_q, flag_d;
  logic      r14_q, r14_d;
  logic      req;
  logic      start;
  logic      finish;

  assign req    = trig_src ? sw_wr : pin_rise;
  assign start  = enable && (state_q == ST_IDLE) && req;
  assign finish = (state_q == ST_CONV) && tmr_done;

  always_comb begin
    state_d = state_q;
    sw_d    = sw_q;
    r14_d   = r14_q;
    flag_d  = flag_q;
    stb_d   = finish;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_CONV;
        sw_d    = trig_src;
        r14_d   = (sub != 2'b00);
      end
      ST_CONV: if (tmr_done) begin
        state_d = ST_IDLE;
        sw_d    = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish)        flag_d = 1'b1;
    else if (drdy_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sw_q    <= 1'b0;
      stb_q   <= 1'b0;
      flag_q  <= 1'b0;
      r14_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
      stb_q   <= stb_d;
      flag_q  <= flag_d;
      r14_q   <= r14_d;
    end
  end

  assign load      = start;
  assign conv_on   = (state_q == ST_CONV);
  assign sw_bit    = sw_q;
  assign drdy_stb  = stb_q;
  assign drdy_flag = flag_q;
  assign res14     = r14_q;

  // R6
  timer_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_on == tmr_active);

  // R4
  sw_bit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> conv_on);

  // R7
  strobe_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ($past(conv_on) && !conv_on && flag_q));

  // R9
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_on && $past(conv_on)) |-> $stable(r14_q));

endmodule

// File: rtl/od_oneshot_ctrl.sv
module od_oneshot_ctrl
  import od_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [SUB_W-1:0]  lp_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              trig_src,
  input  logic              trig_pin,
  input  logic              sw_start_wr,
  input  logic              drdy_clr,
  output logic              fe_power,
  output logic              sw_start_bit,
  output logic              drdy_stb,
  output logic              drdy_flag,
  output logic              res14
);

  logic enable;
  logic pin_rise;
  logic load;
  logic tmr_active;
  logic tmr_done;

  assign enable = (od_mode_e'(mode_sel) == MODE_ONDEMAND) && (rate_sel != '0);

  od_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (trig_pin),
    .pin_rise  (pin_rise)
  );

  od_conv_timer #(.CLK_KHZ(CLK_KHZ)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .sub    (lp_sel),
    .active (tmr_active),
    .done   (tmr_done)
  );

  od_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .trig_src   (trig_src),
    .pin_rise   (pin_rise),
    .sw_wr      (sw_start_wr),
    .drdy_clr   (drdy_clr),
    .sub        (lp_sel),
    .tmr_active (tmr_active),
    .tmr_done   (tmr_done),
    .load       (load),
    .conv_on    (fe_power),
    .sw_bit     (sw_start_bit),
    .drdy_stb   (drdy_stb),
    .drdy_flag  (drdy_flag),
    .res14      (res14)
  );

  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_power && mode_sel != 2'b10) |=> !fe_power);

  // R2
  rate_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_power && rate_sel == '0) |=> !fe_power);

  // R4
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_power && enable && trig_src && sw_start_wr) |=> (fe_power && sw_start_bit));

  // R5
  pin_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_power && trig_src && !sw_start_wr) |=> !fe_power);

endmodule

// File: tb/od_oneshot_ctrl_test.sv
module od_oneshot_ctrl_test;

  localparam int unsigned KHZ = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic [1:0] lp_sel = 2'b00;
  logic [3:0] rate_sel = 4'd1;
  logic       trig_src = 1'b0;
  logic       trig_pin = 1'b0;
  logic       sw_start_wr = 1'b0;
  logic       drdy_clr = 1'b0;
  logic       fe_power, sw_start_bit, drdy_stb, drdy_flag, res14;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  od_oneshot_ctrl #(.CLK_KHZ(KHZ)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lp_sel(lp_sel),
    .rate_sel(rate_sel), .trig_src(trig_src), .trig_pin(trig_pin),
    .sw_start_wr(sw_start_wr), .drdy_clr(drdy_clr), .fe_power(fe_power),
    .sw_start_bit(sw_start_bit), .drdy_stb(drdy_stb), .drdy_flag(drdy_flag),
    .res14(res14)
  );

  function automatic int exp_len(input logic [1:0] lp);
    int us;
    case (lp)
      2'b00: us = 1200;
      2'b01: us = 1700;
      2'b10: us = 2300;
      default: us = 3550;
    endcase
    return (KHZ * us) / 1000;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // fire a trigger and check the start latency
  task automatic fire(input bit src);
    if (src) begin
      sw_start_wr = 1'b1;
      @(negedge clk);
      sw_start_wr = 1'b0;
      chk(fe_power == 1'b1, "R4 start after write", fe_power, 1);
      chk(sw_start_bit == 1'b1, "R4 start bit set", sw_start_bit, 1);
    end else begin
      trig_pin = 1'b1;
      @(negedge clk);
      chk(fe_power == 1'b0, "R3 sync latency 1", fe_power, 0);
      @(negedge clk);
      chk(fe_power == 1'b0, "R3 sync latency 2", fe_power, 0);
      @(negedge clk);
      trig_pin = 1'b0;
      chk(fe_power == 1'b1, "R3 start after sync", fe_power, 1);
      chk(sw_start_bit == 1'b0, "R5 start bit idle on pin", sw_start_bit, 0);
    end
  endtask

  task automatic run_conv(input bit src, input logic [1:0] lp, input bit inject);
    int cnt;
    logic [1:0] lp_keep;
    lp_keep = lp;
    lp_sel = lp;
    trig_src = src;
    @(negedge clk);
    fire(src);
    cnt = 1;
    while (fe_power && cnt < 6000) begin
      @(negedge clk);
      if (inject && cnt == 10) begin
        sw_start_wr = 1'b1;
        trig_pin = 1'b1;
        lp_sel = ~lp_keep;
      end
      if (cnt == 11) sw_start_wr = 1'b0;
      if (cnt == 14) trig_pin = 1'b0;
      if (fe_power) cnt++;
    end
    sw_start_wr = 1'b0;
    trig_pin = 1'b0;
    chk(cnt == exp_len(lp_keep), inject ? "R8 R10 length kept" : "R6 length", cnt, exp_len(lp_keep));
    chk(drdy_stb == 1'b1, "R7 strobe at end", drdy_stb, 1);
    chk(drdy_flag == 1'b1, "R7 flag set", drdy_flag, 1);
    chk(sw_start_bit == 1'b0, "R4 start bit cleared", sw_start_bit, 0);
    chk(res14 == (lp_keep != 2'b00), "R9 R10 result width", res14, int'(lp_keep != 2'b00));
    lp_sel = lp_keep;
    @(negedge clk);
    chk(drdy_stb == 1'b0, "R7 strobe one cycle", drdy_stb, 0);
    chk(drdy_flag == 1'b1, "R7 flag held", drdy_flag, 1);
    drdy_clr = 1'b1;
    @(negedge clk);
    drdy_clr = 1'b0;
    chk(drdy_flag == 1'b0, "R7 flag cleared", drdy_flag, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(fe_power == 1'b0, "R8 no deferred conversion", fe_power, 0);
    end
  endtask

  // attempt both sources and expect nothing to happen
  task automatic expect_ignore(input string tag);
    sw_start_wr = 1'b1;
    trig_pin = 1'b1;
    @(negedge clk);
    sw_start_wr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 3) trig_pin = 1'b0;
      chk(fe_power == 1'b0 && drdy_stb == 1'b0, tag, fe_power, 0);
      chk(sw_start_bit == 1'b0, tag, sw_start_bit, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({fe_power, sw_start_bit, drdy_stb, drdy_flag, res14} == 5'b0, "R11 reset",
        {fe_power, sw_start_bit, drdy_stb, drdy_flag, res14}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every sub-mode from each source
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 4; l++)
        run_conv(s[0], l[1:0], 1'b0);

    // R8 R10 disturbance in mid conversion
    run_conv(1'b1, 2'b00, 1'b1);
    run_conv(1'b0, 2'b11, 1'b1);

    // R5 wrong source
    trig_src = 1'b1;
    trig_pin = 1'b1;
    repeat (3) @(negedge clk);
    trig_pin = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(fe_power == 1'b0, "R5 pin ignored with sw source", fe_power, 0);
    end
    trig_src = 1'b0;
    sw_start_wr = 1'b1;
    @(negedge clk);
    sw_start_wr = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(fe_power == 1'b0 && sw_start_bit == 1'b0, "R5 write ignored with pin source", fe_power, 0);
    end

    // R1 other modes, R2 rate zero
    mode_sel = 2'b00; trig_src = 1'b1; expect_ignore("R1 mode 00");
    mode_sel = 2'b01; trig_src = 1'b0; expect_ignore("R1 mode 01");
    mode_sel = 2'b11; trig_src = 1'b1; expect_ignore("R1 mode 11");
    mode_sel = 2'b10; rate_sel = 4'd0; trig_src = 1'b1; expect_ignore("R2 rate zero sw");
    trig_src = 1'b0; expect_ignore("R2 rate zero pin");
    rate_sel = 4'd9;

    // constrained random mix
    for (int k = 0; k < 16; k++) begin
      if ($urandom % 4 == 0) begin
        mode_sel = 2'($urandom % 4);
        if (mode_sel == 2'b10) rate_sel = 4'd0;
        trig_src = 1'($urandom % 2);
        expect_ignore(mode_sel == 2'b10 ? "R2 random lockout" : "R1 random mode");
        mode_sel = 2'b10;
        rate_sel = 4'(1 + $urandom % 15);
      end else begin
        run_conv(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule